// File: doc/BRIEF.md
# Streaming 2x2 Pixel Window Generator

The block takes a raster-ordered stream of 8-bit grayscale pixels, one per clock when a valid strobe is high, and for every accepted pixel presents a 2x2 neighbourhood. The neighbourhood is the pixel just accepted, the pixel accepted before it on the same line, the pixel exactly one line above the new pixel, and the left neighbour of that upper pixel. A downstream filter or interpolator combines these four taps. It gets a fresh window on every accepted pixel and needs no frame store.

A one-line delay produces the upper taps. It is two pipeline registers, a dual-port RAM run as a circular buffer of depth `LINE_LEN-3` (with its own registered read), and two more registers. The current-line taps come from the front registers and the upper-line taps come from the back registers. A position counter pair tracks column and line. A window-valid flag is raised only when all four taps lie inside the current image. A start-of-frame marker on an accepted pixel restarts the counters and the buffer pointer.

Top module: `pixel_window_2x2`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four taps, `winValid`, `colOut` and `lineOut` are zero.
- R2: One clock after a pixel is accepted (`validIn` high at a rising edge), `tapCur` equals that pixel.
- R3: One clock after an acceptance, `tapLeft` equals the pixel accepted on the acceptance before it.
- R4: One clock after accepting a pixel on line 1 or later, `tapUp` equals the pixel accepted exactly `LINE_LEN` acceptances earlier. If that pixel's column is also 1 or more, `tapUpLeft` equals the pixel accepted `LINE_LEN+1` acceptances earlier.
- R5: Back-to-back accepted pixels each produce their own window on consecutive cycles, with no bubbles inserted.
- R6: `winValid` is 0 after accepting a pixel at column 0 or on line 0.
- R7: `winValid` is 1 after accepting a pixel whose column and line are both nonzero. It is 0 on the cycle after any cycle with `validIn` low.
- R8: A cycle with `validIn` low changes none of the taps, `colOut` or `lineOut`, and does not advance the line delay. Later windows continue as if that cycle had not occurred.
- R9: `colOut` and `lineOut` give the column and line of the pixel in `tapCur`. The column counts 0 to `LINE_LEN-1` and then returns to 0 while the line steps by one. The line returns to 0 after `NUM_LINES-1`.
- R10: A pixel accepted with `sofIn` high is placed at column 0, line 0, and the line delay restarts from it. `sofIn` has no effect while `validIn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Pixel strobe; high accepts `pixIn` |
| sofIn | input | 1 | Marks the accepted pixel as first of a frame |
| pixIn | input | PIX_W | Incoming pixel |
| tapCur | output | PIX_W | Newest pixel |
| tapLeft | output | PIX_W | Left neighbour of newest pixel |
| tapUp | output | PIX_W | Pixel one line above newest |
| tapUpLeft | output | PIX_W | Left neighbour of the upper pixel |
| winValid | output | 1 | All four taps lie inside the image |
| colOut | output | COL_W | Column of `tapCur` |
| lineOut | output | LINE_W | Line of `tapCur` |

## Verification
A buffer pointer that slips or a RAM read that lands one slot off does not show at once. It first shows on the upper taps at the start of line 1, `LINE_LEN` accepted pixels after the frame begins, which is why the bench runs through several full lines and a frame wrap. A counter fault shows on `colOut`, `lineOut` and `winValid` in the very cycle after the bad acceptance. A stall that leaks into the pipeline shows as a moved tap on the cycle after an idle cycle, and later as upper taps shifted by one pixel.

// File: rtl/pw_pkg.sv
package pw_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic adv;      // shift the whole delay line by one pixel
    logic restart;  // accepted pixel opens a frame: rewind the ring
  } pwStrobe_t;

endpackage

// File: rtl/pw_line_ring.sv
module pw_line_ring #(
  parameter int W     = 8,
  parameter int DEPTH = 317
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         adv,
  input  logic         restart,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [W-1:0]      mem [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] addr;

  assign addr = restart ? '0 : ptr;

  // Read and write share one pointer, so slot contents age by DEPTH beats.
  always_ff @(posedge clk) begin
    if (adv) mem[addr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      rdData <= '0;
    end else if (adv) begin
      rdData <= mem[addr];
      ptr    <= (addr == LAST) ? '0 : addr + 1'b1;
    end
  end

  // R4: pointer always addresses a real slot
  p_ptr_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST);

  // R8: ring is frozen when the stream pauses
  p_ring_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !adv |=> $stable(ptr) && $stable(rdData));

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int LINE_LEN  = 320,
  parameter int NUM_LINES = 240,
  parameter int COL_W     = 9,
  parameter int LINE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              sofIn,
  output pwStrobe_t         strobe,
  output logic              winValid,
  output logic [COL_W-1:0]  colOut,
  output logic [LINE_W-1:0] lineOut
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(LINE_LEN - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

  // Position the next accepted pixel will take.
  logic [COL_W-1:0]  colCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [COL_W-1:0]  pixCol;
  logic [LINE_W-1:0] pixLine;

  always_comb begin
    pixCol         = sofIn ? '0 : colCnt;
    pixLine        = sofIn ? '0 : lineCnt;
    strobe.adv     = validIn;
    strobe.restart = validIn && sofIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt   <= '0;
      lineCnt  <= '0;
      colOut   <= '0;
      lineOut  <= '0;
      winValid <= 1'b0;
    end else begin
      winValid <= validIn && (pixCol != '0) && (pixLine != '0);
      if (validIn) begin
        colOut  <= pixCol;
        lineOut <= pixLine;
        if (pixCol == LAST_COL) begin
          colCnt  <= '0;
          lineCnt <= (pixLine == LAST_LINE) ? '0 : pixLine + 1'b1;
        end else begin
          colCnt  <= pixCol + 1'b1;
          lineCnt <= pixLine;
        end
      end
    end
  end

  // R9: counters stay inside the image
  p_col_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    colCnt <= LAST_COL && lineCnt <= LAST_LINE);

  // R7: an idle cycle never yields a window
  p_idle_no_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !winValid);

  // R8: position outputs hold through a stall
  p_pos_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(colOut) && $stable(lineOut));

  // R10: an accepted frame start lands at the origin
  p_sof_origin_r10: assert property (@(posedge clk) disable iff (!rstN)
    validIn && sofIn |=> colOut == '0 && lineOut == '0 && !winValid);

endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 320
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwStrobe_t        strobe,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] tapCur,
  output logic [PIX_W-1:0] tapLeft,
  output logic [PIX_W-1:0] tapUp,
  output logic [PIX_W-1:0] tapUpLeft
);
  // Two entry stages + ring + its read register + two exit stages = one line.
  localparam int RING_DEPTH = LINE_LEN - 3;

  logic [PIX_W-1:0] ringOut;

  pw_line_ring #(
    .W     (PIX_W),
    .DEPTH (RING_DEPTH)
  ) u_ring (
    .clk     (clk),
    .rstN    (rstN),
    .adv     (strobe.adv),
    .restart (strobe.restart),
    .wrData  (tapLeft),
    .rdData  (ringOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapCur    <= '0;
      tapLeft   <= '0;
      tapUp     <= '0;
      tapUpLeft <= '0;
    end else if (strobe.adv) begin
      tapCur    <= pixIn;
      tapLeft   <= tapCur;
      tapUp     <= ringOut;
      tapUpLeft <= tapUp;
    end
  end

  // R3: left tap is the previous newest pixel
  p_left_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adv |=> tapLeft == $past(tapCur));

  // R4: upper-left tap trails the upper tap by one beat
  p_upleft_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.adv |=> tapUpLeft == $past(tapUp));

  // R8: taps frozen while stalled
  p_taps_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.adv |=> $stable(tapCur) && $stable(tapLeft)
                    && $stable(tapUp) && $stable(tapUpLeft));

endmodule

// File: rtl/pixel_window_2x2.sv
module pixel_window_2x2
  import pw_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int LINE_LEN  = 320,
  parameter int NUM_LINES = 240,
  localparam int COL_W    = $clog2(LINE_LEN),
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic              sofIn,
  input  logic [PIX_W-1:0]  pixIn,
  output logic [PIX_W-1:0]  tapCur,
  output logic [PIX_W-1:0]  tapLeft,
  output logic [PIX_W-1:0]  tapUp,
  output logic [PIX_W-1:0]  tapUpLeft,
  output logic              winValid,
  output logic [COL_W-1:0]  colOut,
  output logic [LINE_W-1:0] lineOut
);
  pwStrobe_t strobe;

  pw_ctrl #(
    .LINE_LEN  (LINE_LEN),
    .NUM_LINES (NUM_LINES),
    .COL_W     (COL_W),
    .LINE_W    (LINE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .sofIn    (sofIn),
    .strobe   (strobe),
    .winValid (winValid),
    .colOut   (colOut),
    .lineOut  (lineOut)
  );

  pw_datapath #(
    .PIX_W    (PIX_W),
    .LINE_LEN (LINE_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pixIn     (pixIn),
    .tapCur    (tapCur),
    .tapLeft   (tapLeft),
    .tapUp     (tapUp),
    .tapUpLeft (tapUpLeft)
  );

  // R6: a valid window never sits on the left column or top line
  p_window_inside_r6: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> colOut != '0 && lineOut != '0);

endmodule

// File: tb/tb_pixel_window_2x2.sv
`timescale 1ns/1ps
module tb_pixel_window_2x2;
  localparam int L  = 8;
  localparam int NL = 4;
  localparam int CW = $clog2(L);
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0;
  logic sofIn = 1'b0;
  logic [7:0] pixIn = '0;
  logic [7:0] tapCur, tapLeft, tapUp, tapUpLeft;
  logic winValid;
  logic [CW-1:0] colOut;
  logic [LW-1:0] lineOut;

  always #10 clk = ~clk;

  pixel_window_2x2 #(.PIX_W(8), .LINE_LEN(L), .NUM_LINES(NL)) dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sofIn(sofIn), .pixIn(pixIn),
    .tapCur(tapCur), .tapLeft(tapLeft), .tapUp(tapUp), .tapUpLeft(tapUpLeft),
    .winValid(winValid), .colOut(colOut), .lineOut(lineOut)
  );

  int total = 0;
  int bad = 0;
  int g = 0;
  int mcol = 0;
  int mline = 0;
  int seed = 0;
  int hist [0:1023];

  // Stimulus table: bit1 = validIn, bit0 = sofIn.
  localparam logic [1:0] STIM [0:31] = '{
    2'b11, 2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b00, 2'b00, 2'b10, 2'b10, 2'b10, 2'b01, 2'b10,
    2'b10, 2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nextPix();
    seed++;
    return 8'((seed * 29 + 7) & 8'hFF);
  endfunction

  task automatic step(input bit v, input bit s, input logic [7:0] p);
    int pc, pl, pCur, pLeft, pUp, pUpL, pCol, pLine;
    pCur = tapCur; pLeft = tapLeft; pUp = tapUp; pUpL = tapUpLeft;
    pCol = colOut; pLine = lineOut;
    validIn = v; sofIn = s; pixIn = p;
    @(posedge clk);
    #2;
    if (v) begin
      pc = s ? 0 : mcol;
      pl = s ? 0 : mline;
      hist[g] = p;
      chk(tapCur == p, "R2 tapCur", tapCur, p);
      if (g >= 1) chk(tapLeft == hist[g-1][7:0], "R3 tapLeft", tapLeft, hist[g-1]);
      if (pl >= 1) chk(tapUp == hist[g-L][7:0], "R4 tapUp", tapUp, hist[g-L]);
      if (pl >= 1 && pc >= 1)
        chk(tapUpLeft == hist[g-L-1][7:0], "R4 tapUpLeft", tapUpLeft, hist[g-L-1]);
      chk(winValid == (pc != 0 && pl != 0), "R6/R7 winValid", winValid, (pc != 0 && pl != 0));
      chk(colOut == pc, "R9 colOut", colOut, pc);
      chk(lineOut == pl, "R9/R10 lineOut", lineOut, pl);
      if (pc == L - 1) begin
        mcol = 0;
        mline = (pl == NL - 1) ? 0 : pl + 1;
      end else begin
        mcol = pc + 1;
        mline = pl;
      end
      g++;
    end else begin
      chk(winValid == 1'b0, "R7 idle winValid", winValid, 0);
      chk(tapCur == pCur && tapLeft == pLeft, "R8 front taps hold", tapCur, pCur);
      chk(tapUp == pUp && tapUpLeft == pUpL, "R8 back taps hold", tapUp, pUp);
      chk(colOut == pCol && lineOut == pLine, "R8/R10 position hold", colOut, pCol);
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tapCur == 0 && tapLeft == 0 && tapUp == 0 && tapUpLeft == 0, "R1 taps in reset", tapCur, 0);
    chk(winValid == 0 && colOut == 0 && lineOut == 0, "R1 flags in reset", colOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(tapCur == 0 && winValid == 0 && lineOut == 0, "R1 after release", tapCur, 0);

    // Table walk: frame start, stalls, ignored sof while idle (R8, R10)
    for (int i = 0; i < 32; i++) begin
      step(STIM[i][1], STIM[i][0], nextPix());
    end

    // R5/R9: long unbroken stream, crossing a frame wrap
    for (int i = 0; i < 48; i++) step(1'b1, 1'b0, nextPix());

    // R10: frame start in mid-line, then two full lines
    step(1'b1, 1'b1, nextPix());
    for (int i = 0; i < 2 * L + 3; i++) step(1'b1, 1'b0, nextPix());

    // R8: alternating stall pattern across a line boundary
    for (int i = 0; i < 2 * L; i++) begin
      step(1'b0, 1'b0, 8'hAA);
      step(1'b1, 1'b0, nextPix());
    end

    // R10: sof while idle is ignored, stream continues
    step(1'b0, 1'b1, 8'h55);
    for (int i = 0; i < L + 2; i++) step(1'b1, 1'b0, nextPix());

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule